// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a 32-pin general-purpose input port and turns pin activity into interrupt requests. Each pin is first brought into the local clock domain. It can then pass through a slow-tick debounce filter, and is finally judged either by its level or by its transitions. Software programs a small set of per-pin registers through a plain register port (address, write strobe, write data, combinational read data). Those registers give each pin an enable, a mask, a sense type (level or edge), a polarity and a debounce switch. Software then reads back which pins are pending and retires edge events by writing ones to a clear register.

All pending pins are combined into a single interrupt line. A strap input chooses between two address layouts for the interrupt registers. The enable, debounce and pin-value registers stay put in both layouts. Software can emulate both-edge triggering by flipping a pin's polarity after each event. Polarity writes therefore never manufacture an event of their own.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register reads 0, the status register reads 0 and `irqOut` is low.
- R2: A pin whose type bit is 0 is level sensitive. Its status bit is 1 while its filtered value equals its polarity bit (polarity 1 = active high, 0 = active low), it is enabled and it is unmasked.
- R3: A pin whose type bit is 1 is edge sensitive. A rising transition (polarity 1) or a falling transition (polarity 0) sets a latched event, which stays pending after the pin returns to its old level.
- R4: Only pins whose enable bit is 1 can report status or latch events. Writing a pin's enable bit to 0 discards its latched event.
- R5: A mask bit of 1 hides the pin from status and `irqOut` without discarding its latched event. Clearing the mask bit makes the pending event visible again.
- R6: Writing the clear register with a 1 in a bit discards that pin's latched event. Bits written as 0 leave their pins alone, and the clear register reads as 0.
- R7: An edge detected in the same cycle as a clear write to that pin stays pending.
- R8: A polarity write never creates an event by itself. After the write, the next transition in the newly selected direction is caught.
- R9: `irqOut` is 1 exactly when at least one status bit is 1.
- R10: With its debounce bit set, a pin's filtered value changes only after the new level has been seen at two consecutive `debTick` pulses. A level that does not survive two consecutive ticks is ignored.
- R11: With `altLayout` = 0, the registers sit at enable 0x30, mask 0x34, type 0x38, polarity 0x3c, status 0x40, debounce 0x48, clear 0x4c, pins 0x50. With `altLayout` = 1, mask moves to 0x44, type to 0x34, polarity to 0x38, status to 0x3c and clear to 0x40. Unmapped offsets read 0 and ignore writes.
- R12: The pin-value register returns the two-flop synchronized pin inputs.
- R13: Enable, mask, type, polarity and debounce registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| altLayout | input | 1 | Strap choosing the alternate register layout |
| debTick | input | 1 | Slow clock enable pacing the debounce filter |
| pinsIn | input | 32 | External pin levels, asynchronous |
| addr | input | 8 | Register byte offset |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed register, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that latched events exist only on enabled, edge-sensitive pins. They also check that an all-ones clear empties the latch when no new edge is arriving, that an edge racing a clear survives, and that `irqOut` never rises when every pin is disabled or masked. Behaviour that depends on stimulus history can only be shown by the bench scenarios. This covers pin timing through the synchronizer, the two-tick debounce window and glitch rejection, polarity flips that must not self-trigger, and the alternate layout's moved and unmapped offsets.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register byte offsets shared by both layouts
  localparam logic [7:0] OFF_ENABLE   = 8'h30;
  localparam logic [7:0] OFF_DEBOUNCE = 8'h48;
  localparam logic [7:0] OFF_PINS     = 8'h50;

  // Default layout
  localparam logic [7:0] OFF_MASK_A   = 8'h34;
  localparam logic [7:0] OFF_TYPE_A   = 8'h38;
  localparam logic [7:0] OFF_POL_A    = 8'h3c;
  localparam logic [7:0] OFF_STAT_A   = 8'h40;
  localparam logic [7:0] OFF_CLEAR_A  = 8'h4c;

  // Alternate layout
  localparam logic [7:0] OFF_MASK_B   = 8'h44;
  localparam logic [7:0] OFF_TYPE_B   = 8'h34;
  localparam logic [7:0] OFF_POL_B    = 8'h38;
  localparam logic [7:0] OFF_STAT_B   = 8'h3c;
  localparam logic [7:0] OFF_CLEAR_B  = 8'h40;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_MASK,
    SEL_TYPE,
    SEL_POL,
    SEL_STATUS,
    SEL_DEBOUNCE,
    SEL_CLEAR,
    SEL_PINS
  } regSel_e;

  typedef struct packed {
    logic wrEnable;
    logic wrMask;
    logic wrType;
    logic wrPol;
    logic wrDebounce;
    logic wrClear;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              altLayout,
  output regSel_e           regSel,
  output ctrlStrobes_t      strobes
);

  // Offsets of the registers that move with the strap
  logic [ADDR_W-1:0] offMask, offType, offPol, offStat, offClear;

  always_comb begin
    if (altLayout) begin
      offMask  = ADDR_W'(OFF_MASK_B);
      offType  = ADDR_W'(OFF_TYPE_B);
      offPol   = ADDR_W'(OFF_POL_B);
      offStat  = ADDR_W'(OFF_STAT_B);
      offClear = ADDR_W'(OFF_CLEAR_B);
    end else begin
      offMask  = ADDR_W'(OFF_MASK_A);
      offType  = ADDR_W'(OFF_TYPE_A);
      offPol   = ADDR_W'(OFF_POL_A);
      offStat  = ADDR_W'(OFF_STAT_A);
      offClear = ADDR_W'(OFF_CLEAR_A);
    end
  end

  always_comb begin
    regSel = SEL_NONE;
    if (addr == ADDR_W'(OFF_ENABLE))        regSel = SEL_ENABLE;
    else if (addr == ADDR_W'(OFF_DEBOUNCE)) regSel = SEL_DEBOUNCE;
    else if (addr == ADDR_W'(OFF_PINS))     regSel = SEL_PINS;
    else if (addr == offMask)               regSel = SEL_MASK;
    else if (addr == offType)               regSel = SEL_TYPE;
    else if (addr == offPol)                regSel = SEL_POL;
    else if (addr == offStat)               regSel = SEL_STATUS;
    else if (addr == offClear)              regSel = SEL_CLEAR;
  end

  // Status and pin value are read-only; no strobe exists for them
  always_comb begin
    strobes            = '0;
    strobes.wrEnable   = wrEn && (regSel == SEL_ENABLE);
    strobes.wrMask     = wrEn && (regSel == SEL_MASK);
    strobes.wrType     = wrEn && (regSel == SEL_TYPE);
    strobes.wrPol      = wrEn && (regSel == SEL_POL);
    strobes.wrDebounce = wrEn && (regSel == SEL_DEBOUNCE);
    strobes.wrClear    = wrEn && (regSel == SEL_CLEAR);
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             debTick,
  input  logic [WIDTH-1:0] pinsIn,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] enReg,
  output logic [WIDTH-1:0] maskReg,
  output logic [WIDTH-1:0] typeReg,
  output logic [WIDTH-1:0] polReg,
  output logic [WIDTH-1:0] debReg,
  output logic [WIDTH-1:0] latchReg,
  output logic [WIDTH-1:0] syncPins,
  output logic [WIDTH-1:0] edgeHit,
  output logic [WIDTH-1:0] statusVec
);

  logic [WIDTH-1:0] levelActive;
  logic [WIDTH-1:0] enNext;
  logic [WIDTH-1:0] clearBits;

  // Per-pin front end: synchronizer, debounce filter, transition detector
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic syncA, syncB;
    logic tickSample, debState;
    logic filtered, prevFiltered;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA        <= 1'b0;
        syncB        <= 1'b0;
        tickSample   <= 1'b0;
        debState     <= 1'b0;
        prevFiltered <= 1'b0;
      end else begin
        syncA <= pinsIn[i];
        syncB <= syncA;
        if (!debReg[i]) begin
          // Filter tracks the pin so enabling it starts from the live level
          debState   <= syncB;
          tickSample <= syncB;
        end else if (debTick) begin
          tickSample <= syncB;
          if ((syncB == tickSample) && (syncB != debState)) begin
            debState <= syncB;
          end
        end
        prevFiltered <= filtered;
      end
    end

    assign filtered       = debReg[i] ? debState : syncB;
    assign syncPins[i]    = syncB;
    assign levelActive[i] = (filtered == polReg[i]);
    // Transition found from two samples; polarity only picks the direction
    assign edgeHit[i]     = (filtered != prevFiltered) && (filtered == polReg[i]);
  end

  assign enNext    = strobes.wrEnable ? wrData : enReg;
  assign clearBits = strobes.wrClear ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      maskReg  <= '0;
      typeReg  <= '0;
      polReg   <= '0;
      debReg   <= '0;
      latchReg <= '0;
    end else begin
      enReg <= enNext;
      if (strobes.wrMask)     maskReg <= wrData;
      if (strobes.wrType)     typeReg <= wrData;
      if (strobes.wrPol)      polReg  <= wrData;
      if (strobes.wrDebounce) debReg  <= wrData;
      // New edge wins over a clear in the same cycle; disable discards
      latchReg <= ((latchReg & ~clearBits) | (edgeHit & typeReg)) & enNext;
    end
  end

  assign statusVec = ((levelActive & ~typeReg) | latchReg) & enReg & ~maskReg;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              altLayout,
  input  logic              debTick,
  input  logic [WIDTH-1:0]  pinsIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData,
  output logic              irqOut
);

  regSel_e          regSel;
  ctrlStrobes_t     strobes;
  logic [WIDTH-1:0] enReg, maskReg, typeReg, polReg, debReg;
  logic [WIDTH-1:0] latchReg, syncPins, edgeHit, statusVec;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr      (addr),
    .wrEn      (wrEn),
    .altLayout (altLayout),
    .regSel    (regSel),
    .strobes   (strobes)
  );

  gpio_irq_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .debTick   (debTick),
    .pinsIn    (pinsIn),
    .strobes   (strobes),
    .wrData    (wrData),
    .enReg     (enReg),
    .maskReg   (maskReg),
    .typeReg   (typeReg),
    .polReg    (polReg),
    .debReg    (debReg),
    .latchReg  (latchReg),
    .syncPins  (syncPins),
    .edgeHit   (edgeHit),
    .statusVec (statusVec)
  );

  always_comb begin
    unique case (regSel)
      SEL_ENABLE:   rdData = enReg;
      SEL_MASK:     rdData = maskReg;
      SEL_TYPE:     rdData = typeReg;
      SEL_POL:      rdData = polReg;
      SEL_STATUS:   rdData = statusVec;
      SEL_DEBOUNCE: rdData = debReg;
      SEL_PINS:     rdData = syncPins;
      default:      rdData = '0;
    endcase
  end

  assign irqOut = |statusVec;

endmodule

// File: rtl/gpio_irq_unit_checker.sv
module gpio_irq_unit_checker
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqOut,
  input ctrlStrobes_t     strobes,
  input logic [WIDTH-1:0] wrData,
  input logic [WIDTH-1:0] enReg,
  input logic [WIDTH-1:0] maskReg,
  input logic [WIDTH-1:0] typeReg,
  input logic [WIDTH-1:0] latchReg,
  input logic [WIDTH-1:0] edgeHit
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irqOut);

  assert_latch_only_enabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (latchReg & ~enReg) == '0);

  assert_level_pins_no_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrType |=> (latchReg & ~typeReg) == (latchReg & ~typeReg & $past(typeReg)));

  assert_irq_needs_open_pin_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enReg & ~maskReg) != '0);

  assert_full_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrClear && (&wrData) && ((edgeHit & typeReg) == '0))
      |=> latchReg == '0);

  assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrClear && ((edgeHit & typeReg & enReg & wrData) != '0))
      |=> (latchReg & $past(edgeHit & typeReg & enReg)) == $past(edgeHit & typeReg & enReg));

endmodule

bind gpio_irq_unit gpio_irq_unit_checker #(.WIDTH(WIDTH)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .irqOut   (irqOut),
  .strobes  (strobes),
  .wrData   (wrData),
  .enReg    (enReg),
  .maskReg  (maskReg),
  .typeReg  (typeReg),
  .latchReg (latchReg),
  .edgeHit  (edgeHit)
);

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/100ps
module gpio_irq_unit_bench;

  localparam logic [7:0] A_EN    = 8'h30;
  localparam logic [7:0] A_MASK  = 8'h34;
  localparam logic [7:0] A_TYPE  = 8'h38;
  localparam logic [7:0] A_POL   = 8'h3c;
  localparam logic [7:0] A_STAT  = 8'h40;
  localparam logic [7:0] A_DEB   = 8'h48;
  localparam logic [7:0] A_CLR   = 8'h4c;
  localparam logic [7:0] A_PINS  = 8'h50;
  localparam logic [7:0] B_MASK  = 8'h44;
  localparam logic [7:0] B_TYPE  = 8'h34;
  localparam logic [7:0] B_POL   = 8'h38;
  localparam logic [7:0] B_STAT  = 8'h3c;
  localparam logic [7:0] B_CLR   = 8'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        altLayout = 1'b0;
  logic        debTick = 1'b0;
  logic [31:0] pinsIn = '0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rstN(rstN), .altLayout(altLayout), .debTick(debTick),
    .pinsIn(pinsIn), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] levelStatus(logic [31:0] pins, logic [31:0] pol,
                                              logic [31:0] en, logic [31:0] mask);
    return ~(pins ^ pol) & en & ~mask;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); debTick = 1'b1;
    @(negedge clk); debTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_EN, v);   chk("R1 enable", v, 32'h0);
    rd(A_POL, v);  chk("R1 polarity", v, 32'h0);
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // R13 readback
    wr(A_MASK, 32'hA5A5_0000); rd(A_MASK, v); chk("R13 mask", v, 32'hA5A5_0000);
    wr(A_TYPE, 32'h0F0F_1234); rd(A_TYPE, v); chk("R13 type", v, 32'h0F0F_1234);
    wr(A_POL,  32'h8000_0001); rd(A_POL, v);  chk("R13 polarity", v, 32'h8000_0001);
    wr(A_DEB,  32'h0000_FF00); rd(A_DEB, v);  chk("R13 debounce", v, 32'h0000_FF00);
    wr(A_EN,   32'h1111_2222); rd(A_EN, v);   chk("R13 enable", v, 32'h1111_2222);
    wr(A_MASK, 0); wr(A_TYPE, 0); wr(A_POL, 0); wr(A_DEB, 0); wr(A_EN, 0);

    // R12 pin value register
    pinsIn = 32'h1234_5678; settle();
    rd(A_PINS, v); chk("R12 pins", v, 32'h1234_5678);

    // R2 / R9 random level-mode patterns
    for (int k = 0; k < 24; k++) begin
      logic [31:0] en, mask, pol, pins, exp;
      en = $urandom; mask = $urandom & $urandom; pol = $urandom; pins = $urandom;
      if (k % 6 == 0) mask = ~en;
      wr(A_EN, en); wr(A_MASK, mask); wr(A_POL, pol);
      pinsIn = pins; settle();
      exp = levelStatus(pins, pol, en, mask);
      rd(A_STAT, v); chk("R2 level status", v, exp);
      chk("R9 irqOut", {31'b0, irqOut}, {31'b0, |exp});
    end
    wr(A_EN, 0); wr(A_MASK, 0); wr(A_POL, 0);
    pinsIn = 0; settle();

    // R3 edge latching, rising on low half, falling on high half
    wr(A_TYPE, 32'hFFFF_FFFF); wr(A_POL, 32'h0000_FFFF); wr(A_EN, 32'hFFFF_FFFF);
    pinsIn = 32'h0001_0001; settle();
    rd(A_STAT, v); chk("R3 rising only", v, 32'h0000_0001);
    pinsIn = 32'h0; settle();
    rd(A_STAT, v); chk("R3 falling plus held rising", v, 32'h0001_0001);

    // R6 clear register
    wr(A_CLR, 32'h0000_0001);
    rd(A_STAT, v); chk("R6 partial clear", v, 32'h0001_0000);
    rd(A_CLR, v);  chk("R6 clear reads zero", v, 32'h0);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R6 full clear", v, 32'h0);

    // R5 mask keeps latch
    wr(A_MASK, 32'h2);
    pinsIn = 32'h2; settle();
    rd(A_STAT, v); chk("R5 masked hidden", v, 32'h0);
    chk("R5 masked irqOut", {31'b0, irqOut}, 32'h0);
    wr(A_MASK, 32'h0);
    rd(A_STAT, v); chk("R5 unmasked pending", v, 32'h2);
    wr(A_CLR, 32'h2);

    // R4 disable discards latch
    pinsIn = 32'h6; settle();
    rd(A_STAT, v); chk("R4 latched", v, 32'h4);
    wr(A_EN, ~32'h4);
    rd(A_STAT, v); chk("R4 disabled", v, 32'h0);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R4 latch discarded", v, 32'h0);

    // R8 polarity flip emulating both edges
    pinsIn = 32'hE; settle();
    rd(A_STAT, v); chk("R8 rising caught", v, 32'h8);
    wr(A_CLR, 32'h8);
    wr(A_POL, 32'h0000_FFF7); settle();
    rd(A_STAT, v); chk("R8 no false event", v, 32'h0);
    pinsIn = 32'h6; settle();
    rd(A_STAT, v); chk("R8 falling caught", v, 32'h8);
    wr(A_CLR, 32'hFFFF_FFFF); wr(A_POL, 32'h0000_FFFF);

    // R7 edge racing a clear
    pinsIn = 32'h16; settle();
    pinsIn = 32'h06; settle();
    rd(A_STAT, v); chk("R7 setup latched", v, 32'h10);
    @(negedge clk); pinsIn = 32'h16;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = A_CLR; wrData = 32'h10; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    rd(A_STAT, v); chk("R7 edge survives clear", v, 32'h10);
    wr(A_CLR, 32'hFFFF_FFFF); wr(A_EN, 0); wr(A_TYPE, 0); wr(A_POL, 0);
    pinsIn = 0; settle();

    // R10 debounce
    wr(A_POL, 32'h20); wr(A_DEB, 32'h20); wr(A_EN, 32'h20);
    pinsIn = 32'h20; repeat (10) @(negedge clk);
    rd(A_STAT, v); chk("R10 no ticks yet", v, 32'h0);
    tick();
    rd(A_STAT, v); chk("R10 one tick", v, 32'h0);
    tick();
    rd(A_STAT, v); chk("R10 two ticks", v, 32'h20);
    pinsIn = 32'h0; settle(); tick();
    pinsIn = 32'h20; settle(); tick();
    rd(A_STAT, v); chk("R10 glitch ignored", v, 32'h20);
    rd(A_PINS, v); chk("R12 raw sync with debounce", v, 32'h20);
    wr(A_DEB, 0); wr(A_EN, 0); wr(A_POL, 0);
    pinsIn = 0; settle();

    // R11 alternate layout
    altLayout = 1'b1;
    wr(B_MASK, 32'hF0F0); rd(B_MASK, v); chk("R11 alt mask", v, 32'hF0F0);
    wr(B_TYPE, 32'h40);   rd(B_TYPE, v); chk("R11 alt type", v, 32'h40);
    wr(B_POL, 32'h40);    rd(B_POL, v);  chk("R11 alt polarity", v, 32'h40);
    wr(A_CLR, 32'hFFFF_FFFF); rd(A_CLR, v); chk("R11 alt unmapped", v, 32'h0);
    wr(B_MASK, 0); wr(A_EN, 32'h40);
    pinsIn = 32'h40; settle();
    rd(B_STAT, v); chk("R11 alt status", v, 32'h40);
    wr(B_CLR, 32'h40);
    rd(B_STAT, v); chk("R11 alt clear", v, 32'h0);
    altLayout = 1'b0;
    wr(B_MASK, 32'hFFFF); rd(B_MASK, v); chk("R11 default unmapped", v, 32'h0);
    rd(A_TYPE, v); chk("R11 default type", v, 32'h40);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule